// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel words, one for the left channel and one for the right. It runs on the bit clock, samples the serial data line and the word-select line on each rising edge, and decides from the word-select level which channel the bits belong to. Each finished word appears on its own output bus together with a one-cycle valid pulse. The bus holds the word until the next word for that channel replaces it.

A small configuration register sets the behaviour at run time. It holds the word length, the bit order, which word-select level means left, and whether surplus bits at the start or at the end of a long half-frame are kept. The register is loaded through a write strobe. A hardware reset and a software reset both return it to its defaults. When the master bit is set, the block drives word select itself. Each half-frame is then exactly one programmed word length long, the line changes on the falling edge of the bit clock, and the external word-select input is ignored.

Top module: `audio_serial_rx`

## Requirements
- R1: Hardware reset (`rst`) and software reset (`swRst`) clear the configuration to 16-bit words, MSB first, low level meaning left, keep-first handling and slave mode. They also clear both data buses and both valid strobes, and drive `wsOut` low.
- R2: Length code 0 selects 16 bits, code 1 selects 24 bits, and codes 2 and 3 select 32 bits per word.
- R3: With `cfgLsbFirst` = 0 the first bit of a half-frame lands at bit N-1 of the output, and later bits land at lower positions. With `cfgLsbFirst` = 1 the first bit lands at bit 0, and later bits land at higher positions. N is the word length and all words are right-justified.
- R4: With `cfgLeftHigh` = 0 a half-frame with word select low goes to the left bus and one with word select high goes to the right bus. With `cfgLeftHigh` = 1 the mapping is reversed.
- R5: With `cfgKeepLast` = 0 a word completes on the edge that samples its Nth bit. Any further bits before the next word-select change are dropped.
- R6: With `cfgKeepLast` = 1 a word completes on the edge that samples the first bit at the new word-select level, and it carries the last N bits of the half-frame.
- R7: A half-frame shorter than N bits completes on the edge where word select changes. Its missing positions read as zero: the low bits in MSB-first order and the high bits in LSB-first order.
- R8: Each completed word raises exactly one valid strobe, on the channel's own bus, for one cycle. The data bus holds its value until the next word for that channel.
- R9: In master mode, word select toggles once every N bit-clock cycles and changes only on the falling edge. The receiver then follows its own generated word select and ignores `wsIn`.
- R10: The half-frame that is in progress when reception starts after a reset is never output. Reception begins at the first word-select change.
- R11: In slave mode `wsOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data sampled on rising edge |
| rst | input | 1 | Synchronous hardware reset, active high |
| swRst | input | 1 | Synchronous software reset, active high |
| cfgWe | input | 1 | Loads the configuration fields below |
| cfgLenCode | input | 2 | Word length code (R2) |
| cfgLsbFirst | input | 1 | 1 = LSB first |
| cfgLeftHigh | input | 1 | 1 = word select high means left |
| cfgKeepLast | input | 1 | 1 = keep last N bits of a long half-frame |
| cfgMaster | input | 1 | 1 = generate word select internally |
| wsIn | input | 1 | External word select (slave mode) |
| sdIn | input | 1 | Serial data |
| wsOut | output | 1 | Generated word select (master mode) |
| leftData | output | 32 | Last left word, right-justified |
| leftValid | output | 1 | One-cycle pulse for a new left word |
| rightData | output | 32 | Last right word, right-justified |
| rightValid | output | 1 | One-cycle pulse for a new right word |

## Verification
The bench logs the word-select level and data bit sampled on every edge. From that log it derives the expected words, their channels and their completion edges. It aims at half-frames of one bit, of exactly N bits and of several bits beyond N, under both surplus-bit rules and both bit orders:
- A design that miscounts would complete keep-first words one edge late or early.
- A design that zero-fills on the wrong side would scramble short words.
- A design that keeps the wrong end of a long frame would shift keep-last data.

In master mode the bench drives random levels on `wsIn` and checks that every generated half-frame is exactly N cycles long. It also runs trials after each kind of reset without writing the configuration, so a default that fails to clear shows up as wrongly placed data.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int DATA_W    = 32;
  localparam int CNT_W     = $clog2(DATA_W + 1);
  localparam int LEN_SHORT = 16;
  localparam int LEN_MID   = 24;
  localparam int LEN_LONG  = DATA_W;

  typedef struct packed {
    logic [1:0] lenCode;
    logic       lsbFirst;
    logic       leftHigh;
    logic       keepLast;
    logic       master;
  } sar_cfg_t;

  // Strobes from control to datapath, one set per bit-clock cycle.
  typedef struct packed {
    logic             loadFirst;  // start a new word with this bit
    logic             shiftIn;    // append this bit to the current word
    logic             emit;       // a word completes this cycle
    logic             emitNow;    // completed word includes this cycle's bit
    logic             emitLeft;   // destination channel
    logic [CNT_W-1:0] emitCount;  // bits held in the stored word
  } sar_strb_t;

  function automatic logic [CNT_W-1:0] wordLenOf(input logic [1:0] code);
    case (code)
      2'd0:    wordLenOf = CNT_W'(LEN_SHORT);
      2'd1:    wordLenOf = CNT_W'(LEN_MID);
      default: wordLenOf = CNT_W'(LEN_LONG);
    endcase
  endfunction

endpackage

// File: rtl/sar_rx_ctrl.sv
module sar_rx_ctrl
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             swRst,
  input  logic             cfgWe,
  input  sar_cfg_t         cfgIn,
  input  logic             wsPin,
  output sar_cfg_t         cfgOut,
  output logic [CNT_W-1:0] wordLen,
  output logic             wsOut,
  output sar_strb_t        strb
);

  logic             clear;
  sar_cfg_t         cfgReg;
  logic [CNT_W-1:0] lenM1;

  // master-mode word-select generator
  logic [CNT_W-1:0] genCnt;
  logic             genLevel;
  logic             wsDrive;

  // receive tracking
  logic             primed;
  logic             inWord;
  logic             done;
  logic             wsPrev;
  logic [CNT_W-1:0] bitCount;
  logic             wsSeen;
  logic             toggle;

  assign clear   = rst | swRst;
  assign wordLen = wordLenOf(cfgReg.lenCode);
  assign lenM1   = wordLen - CNT_W'(1);
  assign cfgOut  = cfgReg;
  assign wsOut   = wsDrive;

  always_ff @(posedge clk) begin
    if (clear)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgIn;
  end

  // Generator counts on the rising edge; the line itself moves on the falling edge.
  always_ff @(posedge clk) begin
    if (clear || !cfgReg.master) begin
      genCnt   <= '0;
      genLevel <= 1'b0;
    end else if (genCnt >= lenM1) begin
      genCnt   <= '0;
      genLevel <= ~genLevel;
    end else begin
      genCnt   <= genCnt + CNT_W'(1);
    end
  end

  always_ff @(negedge clk) begin
    if (clear || !cfgReg.master) wsDrive <= 1'b0;
    else                         wsDrive <= genLevel;
  end

  assign wsSeen = cfgReg.master ? wsDrive : wsPin;
  assign toggle = primed && (wsSeen != wsPrev);

  always_comb begin
    strb           = '0;
    strb.emitCount = bitCount;
    strb.emitLeft  = (wsPrev == cfgReg.leftHigh);
    if (primed) begin
      if (toggle) begin
        strb.loadFirst = 1'b1;
        strb.emit      = inWord && !done;
      end else if (inWord && !done) begin
        strb.shiftIn = 1'b1;
        if (!cfgReg.keepLast && bitCount >= lenM1) begin
          strb.emit      = 1'b1;
          strb.emitNow   = 1'b1;
          strb.emitCount = wordLen;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      primed   <= 1'b0;
      inWord   <= 1'b0;
      done     <= 1'b0;
      wsPrev   <= 1'b0;
      bitCount <= '0;
    end else begin
      primed <= 1'b1;
      wsPrev <= wsSeen;
      if (toggle) begin
        inWord   <= 1'b1;
        done     <= 1'b0;
        bitCount <= CNT_W'(1);
      end else if (inWord && !done) begin
        if (bitCount < wordLen) bitCount <= bitCount + CNT_W'(1);
        if (!cfgReg.keepLast && bitCount >= lenM1) done <= 1'b1;
      end
    end
  end

  // R1: software reset returns configuration and tracking to idle
  p_swreset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    swRst |=> (cfgReg == '0 && !inWord && bitCount == '0));

  // R9: generated level only moves when a full word length has elapsed
  p_gen_hold_r9: assert property (@(posedge clk) disable iff (clear)
    (cfgReg.master && !cfgWe && genCnt < lenM1) |=> $stable(genLevel));

  // R11: no generated word select while in slave mode
  p_slave_ws_low_r11: assert property (@(posedge clk) disable iff (clear)
    !cfgReg.master |-> !wsDrive);

endmodule

// File: rtl/sar_rx_dpath.sv
module sar_rx_dpath
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              clear,
  input  logic              cfgLsb,
  input  logic [CNT_W-1:0]  wordLen,
  input  logic              sdIn,
  input  sar_strb_t         strb,
  output logic [DATA_W-1:0] leftData,
  output logic              leftValid,
  output logic [DATA_W-1:0] rightData,
  output logic              rightValid
);

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] oneBit;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] emitVal;
  logic [CNT_W-1:0]  gap;

  logic [DATA_W-1:0] chanData  [2];
  logic              chanValid [2];

  assign mask    = {DATA_W{1'b1}} >> (DATA_W - int'(wordLen));
  assign base    = strb.loadFirst ? '0 : acc;
  assign oneBit  = {{(DATA_W-1){1'b0}}, sdIn};
  assign shifted = cfgLsb ? ((base >> 1) | (oneBit << (wordLen - CNT_W'(1))))
                          : (((base << 1) | oneBit) & mask);
  assign gap     = wordLen - strb.emitCount;
  assign aligned = cfgLsb ? (acc >> gap) : ((acc << gap) & mask);
  assign emitVal = strb.emitNow ? shifted : aligned;

  always_ff @(posedge clk) begin
    if (clear)                               acc <= '0;
    else if (strb.loadFirst || strb.shiftIn) acc <= shifted;
  end

  // index 0 = right, index 1 = left
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (clear) begin
        chanData[ch]  <= '0;
        chanValid[ch] <= 1'b0;
      end else begin
        chanValid[ch] <= strb.emit && (strb.emitLeft == (ch == 1));
        if (strb.emit && (strb.emitLeft == (ch == 1))) chanData[ch] <= emitVal;
      end
    end
  end

  assign leftData   = chanData[1];
  assign leftValid  = chanValid[1];
  assign rightData  = chanData[0];
  assign rightValid = chanValid[0];

  // R8: one word goes to one channel only
  p_valid_exclusive_r8: assert property (@(posedge clk) disable iff (clear)
    !(leftValid && rightValid));

  // R7: a short MSB-first left word has zero in its lowest bit
  p_short_fill_r7: assert property (@(posedge clk) disable iff (clear)
    (strb.emit && strb.emitLeft && !strb.emitNow && !cfgLsb && strb.emitCount < wordLen)
    |=> (leftData[0] == 1'b0));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              swRst,
  input  logic              cfgWe,
  input  logic [1:0]        cfgLenCode,
  input  logic              cfgLsbFirst,
  input  logic              cfgLeftHigh,
  input  logic              cfgKeepLast,
  input  logic              cfgMaster,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              wsOut,
  output logic [DATA_W-1:0] leftData,
  output logic              leftValid,
  output logic [DATA_W-1:0] rightData,
  output logic              rightValid
);

  sar_cfg_t         cfgIn;
  sar_cfg_t         cfgCur;
  sar_strb_t        strb;
  logic [CNT_W-1:0] wordLen;
  logic             clear;

  assign clear = rst | swRst;
  assign cfgIn = '{lenCode: cfgLenCode, lsbFirst: cfgLsbFirst, leftHigh: cfgLeftHigh,
                   keepLast: cfgKeepLast, master: cfgMaster};

  sar_rx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .swRst   (swRst),
    .cfgWe   (cfgWe),
    .cfgIn   (cfgIn),
    .wsPin   (wsIn),
    .cfgOut  (cfgCur),
    .wordLen (wordLen),
    .wsOut   (wsOut),
    .strb    (strb)
  );

  sar_rx_dpath u_dpath (
    .clk        (clk),
    .clear      (clear),
    .cfgLsb     (cfgCur.lsbFirst),
    .wordLen    (wordLen),
    .sdIn       (sdIn),
    .strb       (strb),
    .leftData   (leftData),
    .leftValid  (leftValid),
    .rightData  (rightData),
    .rightValid (rightValid)
  );

  // R8: a left word pulse lasts a single cycle while the mapping is unchanged
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (clear)
    (leftValid && !$past(cfgWe)) |=> !leftValid);

endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swRst = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgLenCode = 2'd0;
  logic        cfgLsbFirst = 1'b0;
  logic        cfgLeftHigh = 1'b0;
  logic        cfgKeepLast = 1'b0;
  logic        cfgMaster = 1'b0;
  logic        wsIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        wsOut;
  logic [31:0] leftData;
  logic        leftValid;
  logic [31:0] rightData;
  logic        rightValid;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst(rst), .swRst(swRst), .cfgWe(cfgWe), .cfgLenCode(cfgLenCode),
    .cfgLsbFirst(cfgLsbFirst), .cfgLeftHigh(cfgLeftHigh), .cfgKeepLast(cfgKeepLast),
    .cfgMaster(cfgMaster), .wsIn(wsIn), .sdIn(sdIn), .wsOut(wsOut),
    .leftData(leftData), .leftValid(leftValid), .rightData(rightData), .rightValid(rightValid)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    bit          left;
    logic [31:0] data;
    int          edgeId;
    int          kind;
  } em_t;

  em_t gotQ[$];
  em_t expQ[$];
  bit  wsLog [512];
  bit  sdLog [512];
  int  logN;
  int  baseEdge;
  int  edgeCnt = 0;
  bit  recording = 1'b0;
  int  nChecks = 0;
  int  nFail = 0;
  int  tLen;
  bit  tLsb, tLeftHigh, tKeepLast, tMaster, tDefault;
  bit  slaveWsBad;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  always @(negedge clk) begin
    if (recording) begin
      em_t e;
      if (leftValid) begin
        e.left = 1'b1; e.data = leftData; e.edgeId = edgeCnt - 1; e.kind = 0;
        gotQ.push_back(e);
      end
      if (rightValid) begin
        e.left = 1'b0; e.data = rightData; e.edgeId = edgeCnt - 1; e.kind = 0;
        gotQ.push_back(e);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input bit [1:0] code);
    return (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
  endfunction

  task automatic startTrial(input bit useHw, input bit doWrite, input bit [1:0] code,
                            input bit lsb, input bit lh, input bit kl, input bit ms,
                            input bit lvl);
    @(negedge clk);
    cfgWe = 1'b0;
    if (useHw) rst = 1'b1; else swRst = 1'b1;
    @(negedge clk);
    rst = 1'b0; swRst = 1'b0;
    cfgWe = doWrite; cfgLenCode = code; cfgLsbFirst = lsb; cfgLeftHigh = lh;
    cfgKeepLast = kl; cfgMaster = ms;
    tDefault  = !doWrite;
    tLen      = doWrite ? lenOf(code) : 16;
    tLsb      = doWrite ? lsb : 1'b0;
    tLeftHigh = doWrite ? lh : 1'b0;
    tKeepLast = doWrite ? kl : 1'b0;
    tMaster   = doWrite ? ms : 1'b0;
    slaveWsBad = 1'b0;
    wsIn = lvl;
    sdIn = 1'($urandom());
    gotQ.delete();
    baseEdge = edgeCnt;
    wsLog[0] = lvl;
    sdLog[0] = sdIn;
    logN = 1;
    recording = 1'b1;
  endtask

  task automatic stepLog(input bit ws, input bit sd);
    @(negedge clk);
    cfgWe = 1'b0;
    wsIn = ws;
    sdIn = sd;
    #1;
    if (!tMaster && wsOut !== 1'b0) slaveWsBad = 1'b1;
    wsLog[logN] = tMaster ? wsOut : ws;
    sdLog[logN] = sd;
    logN++;
  endtask

  // Expected word for one run of constant word select [s..e]; t is the toggle index.
  task automatic modelRun(input int s, input int e, input bit complete, input int t);
    em_t x;
    int k, m, w0;
    k = e - s + 1;
    if (!tKeepLast && k >= tLen) begin
      m = tLen; w0 = s; x.edgeId = baseEdge + s + tLen - 1; x.kind = 5;
    end else if (complete) begin
      m = (k < tLen) ? k : tLen;
      w0 = tKeepLast ? (e - m + 1) : s;
      x.edgeId = baseEdge + t;
      x.kind = (k < tLen) ? 7 : 6;
    end else begin
      return;
    end
    x.data = '0;
    for (int j = 0; j < m; j++) begin
      int pos;
      pos = tLsb ? j : (tLen - 1 - j);
      x.data[pos] = sdLog[w0 + j];
    end
    x.left = (wsLog[s] == tLeftHigh);
    expQ.push_back(x);
  endtask

  task automatic endTrial();
    int runStart;
    int n;
    @(negedge clk);
    swRst = 1'b1;
    @(negedge clk);
    swRst = 1'b0;
    recording = 1'b0;
    expQ.delete();
    runStart = 0;
    for (int i = 1; i <= logN; i++) begin
      if (i == logN || wsLog[i] != wsLog[i-1]) begin
        if (runStart != 0) begin
          modelRun(runStart, i - 1, i < logN, i);
          if (tMaster && i < logN)
            check(i - runStart == tLen, "R9", "master half-frame length",
                  64'(i - runStart), 64'(tLen));
        end
        runStart = i;
      end
    end
    if (!tMaster) check(!slaveWsBad, "R11", "wsOut low in slave mode", 64'(slaveWsBad), 64'd0);
    check(gotQ.size() == expQ.size(), "R8 R10", "word count",
          64'(gotQ.size()), 64'(expQ.size()));
    n = (gotQ.size() < expQ.size()) ? gotQ.size() : expQ.size();
    for (int i = 0; i < n; i++) begin
      string tag;
      tag = (expQ[i].kind == 5) ? "R5" : (expQ[i].kind == 6) ? "R6" : "R7";
      if (tDefault) tag = {"R1 ", tag};
      check(gotQ[i].left == expQ[i].left, "R4", "channel",
            64'(gotQ[i].left), 64'(expQ[i].left));
      check(gotQ[i].data == expQ[i].data, {"R2 R3 ", tag}, "word data",
            64'(gotQ[i].data), 64'(expQ[i].data));
      check(gotQ[i].edgeId == expQ[i].edgeId, tag, "completion edge",
            64'(gotQ[i].edgeId), 64'(expQ[i].edgeId));
    end
  endtask

  function automatic int halfLen(input int mode, input int idx, input int n);
    int r;
    if (mode == 1) begin
      case (idx)
        0: return 1;
        1: return n;
        2: return n + 4;
        3: return n - 1;
        4: return 2;
        default: return n + 1;
      endcase
    end
    r = $urandom_range(0, 3);
    if (r == 0) return $urandom_range(1, n - 1);
    if (r == 1) return n;
    return $urandom_range(n + 1, n + 5);
  endfunction

  task automatic runSlave(input bit useHw, input bit doWrite, input int mode,
                          input bit [1:0] code, input bit lsb, input bit lh, input bit kl);
    bit lvl;
    lvl = 1'($urandom());
    startTrial(useHw, doWrite, code, lsb, lh, kl, 1'b0, lvl);
    stepLog(lvl, 1'($urandom()));
    for (int h = 0; h < 6; h++) begin
      int k;
      lvl = ~lvl;
      k = halfLen(mode, h, tLen);
      for (int b = 0; b < k; b++) stepLog(lvl, 1'($urandom()));
    end
    stepLog(~lvl, 1'($urandom()));
    endTrial();
  endtask

  task automatic runMaster(input bit [1:0] code, input bit kl);
    startTrial(1'b0, 1'b1, code, 1'($urandom()), 1'($urandom()), kl, 1'b1, 1'b0);
    for (int i = 0; i < 5 * lenOf(code) + 3; i++) stepLog(1'($urandom()), 1'($urandom()));
    endTrial();
  endtask

  initial begin
    void'($urandom(32'h5A17C0DE));
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(leftValid == 1'b0 && rightValid == 1'b0, "R1", "valids in reset",
          64'({leftValid, rightValid}), 64'd0);
    check(leftData == '0 && rightData == '0, "R1", "data in reset",
          64'(leftData | rightData), 64'd0);
    check(wsOut == 1'b0, "R1", "wsOut in reset", 64'(wsOut), 64'd0);

    // directed length patterns: 1, N, N+4, N-1, 2, N+1
    runSlave(1'b0, 1'b1, 1, 2'd0, 1'b0, 1'b0, 1'b0);
    runSlave(1'b0, 1'b1, 1, 2'd1, 1'b1, 1'b1, 1'b0);
    runSlave(1'b0, 1'b1, 1, 2'd2, 1'b0, 1'b1, 1'b1);
    runSlave(1'b0, 1'b1, 1, 2'd3, 1'b1, 1'b0, 1'b1);
    // defaults after software and hardware reset, without a configuration write
    runSlave(1'b0, 1'b1, 1, 2'd2, 1'b1, 1'b1, 1'b1);
    runSlave(1'b0, 1'b0, 1, 2'd0, 1'b0, 1'b0, 1'b0);
    runSlave(1'b0, 1'b1, 0, 2'd1, 1'b1, 1'b1, 1'b1);
    runSlave(1'b1, 1'b0, 0, 2'd0, 1'b0, 1'b0, 1'b0);

    for (int t = 0; t < 40; t++)
      runSlave(1'b0, 1'b1, 0, 2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));

    runMaster(2'd0, 1'b0);
    runMaster(2'd1, 1'b1);
    runMaster(2'd3, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule